// File: doc/BRIEF.md
# Counter Snapshot Capture Queue

This block records snapshots of a counter channel. Each snapshot holds the counter value, the free-running timestamp and a reason vector, all taken in the clock cycle in which an enabled trigger fires. Snapshots go into a 16-entry circular queue. When the queue is full, a new snapshot replaces the oldest one and never stalls. The counter core, the timestamp source and the quadrature decoder sit outside the block and drive its inputs.

A host drains the queue through a registered read port. A read of the count selector removes the head entry and returns its count. The same read also copies the entry's timestamp and reason into a hold register. Timestamp and reason reads come from that hold register. This keeps the three fields of one entry together, even when later triggers overwrite queue slots. Each hardware trigger has its own enable. The software strobe always captures. The quadrature-error trigger captures once and then stays quiet until it is re-armed.

Two small state machines control the block. The host read machine has two states. It moves from HS_IDLE to HS_HELD when a count read pops an entry. It stays in HS_HELD on further pops. It returns to HS_IDLE when a count read finds the queue empty. The error-arming machine also has two states. It moves from QA_ARMED to QA_SPENT when an error capture happens without a clear in the same cycle, and returns from QA_SPENT to QA_ARMED on qerr_clr. DEPTH must be a power of two.

Top module: `snap_capture_queue`

## Requirements
- R1: An entry stores cnt_in and ts_in from the same clock cycle in which its trigger fires.
- R2: The reason vector has bit 0 for the software strobe, bit 1 for compare, bit 2 for index edge, bit 3 for external edge, bit 4 for zero count and bit 5 for quadrature error. Triggers that fire in the same cycle set several bits of one entry. A cycle whose reason vector is zero stores nothing.
- R3: The queue holds up to 16 entries. q_level gives the entry count and q_empty is high when the count is zero.
- R4: A capture into a full queue stores the new entry, discards the oldest one, and leaves q_level at 16.
- R5: With rd_sel=0 (count), a read returns the head count one cycle later and pops the head. It also copies the head's timestamp and reason into a hold register. rd_sel=1 returns the held timestamp and rd_sel=2 returns the held reason. Captures that happen after the pop do not change the held values.
- R6: trig_en enables the hardware triggers: bit 0 compare, bit 5 zero count, bit 6 quadrature error. A disabled trigger stores nothing. The software strobe captures regardless of trig_en.
- R7: After a quadrature-error capture, later error inputs capture nothing until a qerr_clr pulse re-arms the trigger.
- R8: A count read on an empty queue returns zero on rd_data and pulses rd_miss for one cycle.
- R9: A capture and a pop in the same cycle on a full queue return the old head and leave q_level at 16. They discard nothing and do not set ovf_flag.
- R10: ovf_flag goes high when an entry is discarded and stays high until an ovf_clr pulse.
- R11: trig_en enables the edge triggers: bit 1 index rising, bit 2 index falling, bit 3 external rising, bit 4 external falling. An edge is detected against the input's value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_in | input | CNT_W | Live counter value |
| ts_in | input | TS_W | Live timestamp |
| sw_trig | input | 1 | Software capture strobe |
| cmp_match | input | 1 | Compare match level |
| idx_in | input | 1 | Index input |
| ext_in | input | 1 | External input |
| zero_cnt | input | 1 | Counter-at-zero level |
| qerr_in | input | 1 | Quadrature error level |
| qerr_clr | input | 1 | Re-arm the error trigger |
| trig_en | input | 7 | Hardware trigger enables |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 2 | 0 count/pop, 1 timestamp, 2 reason, 3 zero |
| ovf_clr | input | 1 | Clear overflow flag |
| rd_data | output | max(CNT_W,TS_W) | Registered read data |
| rd_miss | output | 1 | Count read found the queue empty |
| q_empty | output | 1 | Queue empty |
| q_level | output | log2(DEPTH)+1 | Entry count |
| ovf_flag | output | 1 | Sticky discard flag |

## Verification
The hardest case to reach is a full queue that receives a capture and a pop in the same cycle, with the overflow flag already clear. The stimulus first overfills the queue with software strobes and checks that the oldest entry is gone. It then pops once and overfills again, so that a discard happens while an entry sits in the hold register. Finally it clears the flag and, in a single cycle, drives a count read together with a strobe. The error-arming path is checked twice: once while the trigger is still spent from earlier table vectors, and again after an explicit qerr_clr.

// File: rtl/snapq_pkg.sv
package snapq_pkg;
    localparam int NRSN = 6;
    localparam int NEN  = 7;

    localparam int RB_SOFT = 0;
    localparam int RB_CMP  = 1;
    localparam int RB_IDX  = 2;
    localparam int RB_EXT  = 3;
    localparam int RB_ZERO = 4;
    localparam int RB_QERR = 5;

    localparam int EB_CMP   = 0;
    localparam int EB_IDX_R = 1;
    localparam int EB_IDX_F = 2;
    localparam int EB_EXT_R = 3;
    localparam int EB_EXT_F = 4;
    localparam int EB_ZERO  = 5;
    localparam int EB_QERR  = 6;

    typedef logic [NRSN-1:0] rsn_t;

    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_TS   = 2'd1,
        SEL_RSN  = 2'd2,
        SEL_NONE = 2'd3
    } rd_sel_e;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_HELD = 1'b1
    } host_st_e;

    typedef enum logic {
        QA_ARMED = 1'b0,
        QA_SPENT = 1'b1
    } qerr_st_e;
endpackage

// File: rtl/snapq_trig.sv
module snapq_trig
    import snapq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_trig,
    input  logic           cmp_match,
    input  logic           idx_in,
    input  logic           ext_in,
    input  logic           zero_cnt,
    input  logic           qerr_in,
    input  logic           qerr_clr,
    input  logic [NEN-1:0] trig_en,
    output rsn_t           rsn
);
    localparam int NEDGE = 2;

    logic [NEDGE-1:0] lvl_now;
    logic [NEDGE-1:0] lvl_q;
    logic [NEDGE-1:0] edge_hit;
    qerr_st_e         qst, qst_nx;
    logic             qfire;

    assign lvl_now = {ext_in, idx_in};

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_now;
    end

    // channel 0 = index, channel 1 = external; enables sit in pairs
    for (genvar g = 0; g < NEDGE; g++) begin : g_edge
        assign edge_hit[g] = (trig_en[EB_IDX_R + 2*g] &  lvl_now[g] & ~lvl_q[g])
                           | (trig_en[EB_IDX_F + 2*g] & ~lvl_now[g] &  lvl_q[g]);
    end

    assign qfire = trig_en[EB_QERR] && qerr_in && (qst == QA_ARMED);

    always_ff @(posedge clk) begin
        if (!rst_n) qst <= QA_ARMED;
        else        qst <= qst_nx;
    end

    // a clear in the same cycle as an error capture keeps the trigger armed
    always_comb begin
        qst_nx = qst;
        unique case (qst)
            QA_ARMED: if (qfire && !qerr_clr) qst_nx = QA_SPENT;
            QA_SPENT: if (qerr_clr)           qst_nx = QA_ARMED;
            default:                          qst_nx = QA_ARMED;
        endcase
    end

    always_comb begin
        rsn          = '0;
        rsn[RB_SOFT] = sw_trig;
        rsn[RB_CMP]  = cmp_match && trig_en[EB_CMP];
        rsn[RB_IDX]  = edge_hit[0];
        rsn[RB_EXT]  = edge_hit[1];
        rsn[RB_ZERO] = zero_cnt && trig_en[EB_ZERO];
        rsn[RB_QERR] = qfire;
    end

    assert_qerr_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsn[RB_QERR] && !qerr_clr) |=> !rsn[RB_QERR]);
endmodule

// File: rtl/snapq_store.sv
module snapq_store
    import snapq_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TS_W  = 32,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  rsn_t                     rsn_in,
    input  logic [CNT_W-1:0]         cnt_in,
    input  logic [TS_W-1:0]          ts_in,
    input  logic                     pop_req,
    input  logic                     ovf_clr,
    output logic [CNT_W-1:0]         head_cnt,
    output logic [TS_W-1:0]          head_ts,
    output rsn_t                     head_rsn,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level,
    output logic                     ovf_flag
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = PTR_W + 1;
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    logic [CNT_W-1:0] cnt_mem [DEPTH];
    logic [TS_W-1:0]  ts_mem  [DEPTH];
    rsn_t             rsn_mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             full, push, pop, drop;

    assign full  = (level == LVL_FULL);
    assign empty = (level == '0);
    assign push  = |rsn_in;
    assign pop   = pop_req && !empty;
    // with a pop in the same cycle the slot frees first, so nothing is lost
    assign drop  = push && !pop && full;

    always_ff @(posedge clk) begin
        if (push) begin
            cnt_mem[wptr] <= cnt_in;
            ts_mem[wptr]  <= ts_in;
            rsn_mem[wptr] <= rsn_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push)        wptr <= wptr + PTR_W'(1);
            if (pop || drop) rptr <= rptr + PTR_W'(1);
            if (push && !pop && !full) level <= level + LVL_W'(1);
            else if (pop && !push)     level <= level - LVL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (drop)    ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

    assign head_cnt = cnt_mem[rptr];
    assign head_ts  = ts_mem[rptr];
    assign head_rsn = rsn_mem[rptr];

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_FULL);
    assert_full_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && ovf_flag));
    assert_swap_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && pop_req && !ovf_flag) |=> (full && !ovf_flag));
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: rtl/snapq_host.sv
module snapq_host
    import snapq_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TS_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    input  logic              empty,
    input  logic [CNT_W-1:0]  head_cnt,
    input  logic [TS_W-1:0]   head_ts,
    input  rsn_t              head_rsn,
    output logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_miss
);
    host_st_e        st, st_nx;
    rd_sel_e         sel;
    logic            cnt_rd;
    logic [TS_W-1:0] hold_ts;
    rsn_t            hold_rsn;

    assign sel    = rd_sel_e'(rd_sel);
    assign cnt_rd = rd_en && (sel == SEL_CNT);
    assign pop    = cnt_rd && !empty;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= HS_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            HS_IDLE: if (pop)             st_nx = HS_HELD;
            HS_HELD: if (cnt_rd && empty) st_nx = HS_IDLE;
            default:                      st_nx = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_ts  <= '0;
            hold_rsn <= '0;
        end else if (pop) begin
            hold_ts  <= head_ts;
            hold_rsn <= head_rsn;
        end else if (cnt_rd) begin
            hold_ts  <= '0;
            hold_rsn <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_miss <= 1'b0;
        end else begin
            rd_miss <= cnt_rd && empty;
            if (rd_en) begin
                unique case (sel)
                    SEL_CNT:  rd_data <= empty ? '0 : DATA_W'(head_cnt);
                    SEL_TS:   rd_data <= (st == HS_HELD) ? DATA_W'(hold_ts) : '0;
                    SEL_RSN:  rd_data <= (st == HS_HELD) ? DATA_W'(hold_rsn) : '0;
                    SEL_NONE: rd_data <= '0;
                    default:  rd_data <= '0;
                endcase
            end
        end
    end

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && empty) |=> (rd_miss && rd_data == '0));
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_rd |=> ($stable(hold_ts) && $stable(hold_rsn)));
endmodule

// File: rtl/snap_capture_queue.sv
module snap_capture_queue
    import snapq_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TS_W  = 32,
    parameter int DEPTH = 16,
    localparam int DATA_W = (CNT_W > TS_W) ? CNT_W : TS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       cnt_in,
    input  logic [TS_W-1:0]        ts_in,
    input  logic                   sw_trig,
    input  logic                   cmp_match,
    input  logic                   idx_in,
    input  logic                   ext_in,
    input  logic                   zero_cnt,
    input  logic                   qerr_in,
    input  logic                   qerr_clr,
    input  logic [NEN-1:0]         trig_en,
    input  logic                   rd_en,
    input  logic [1:0]             rd_sel,
    input  logic                   ovf_clr,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   rd_miss,
    output logic                   q_empty,
    output logic [$clog2(DEPTH):0] q_level,
    output logic                   ovf_flag
);
    rsn_t             rsn;
    logic [CNT_W-1:0] head_cnt;
    logic [TS_W-1:0]  head_ts;
    rsn_t             head_rsn;
    logic             pop;

    snapq_trig u_trig (
        .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .cmp_match(cmp_match),
        .idx_in(idx_in), .ext_in(ext_in), .zero_cnt(zero_cnt),
        .qerr_in(qerr_in), .qerr_clr(qerr_clr), .trig_en(trig_en), .rsn(rsn)
    );

    snapq_store #(.CNT_W(CNT_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .rsn_in(rsn), .cnt_in(cnt_in), .ts_in(ts_in),
        .pop_req(pop), .ovf_clr(ovf_clr), .head_cnt(head_cnt), .head_ts(head_ts),
        .head_rsn(head_rsn), .empty(q_empty), .level(q_level), .ovf_flag(ovf_flag)
    );

    snapq_host #(.CNT_W(CNT_W), .TS_W(TS_W), .DATA_W(DATA_W)) u_host (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .empty(q_empty),
        .head_cnt(head_cnt), .head_ts(head_ts), .head_rsn(head_rsn),
        .pop(pop), .rd_data(rd_data), .rd_miss(rd_miss)
    );
endmodule

// File: tb/snap_capture_queue_bench.sv
module snap_capture_queue_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;
    // {sw,cmp,idx,ext,zero,qerr} , trig_en[6:0] , expected reason[5:0]
    localparam logic [18:0] VEC [NVEC] = '{
        {6'b100000, 7'b0000000, 6'b000001},
        {6'b010000, 7'b0000000, 6'b000000},
        {6'b010000, 7'b0000001, 6'b000010},
        {6'b001000, 7'b0000010, 6'b000100},
        {6'b000000, 7'b0000010, 6'b000000},
        {6'b001000, 7'b0000100, 6'b000000},
        {6'b000000, 7'b0000100, 6'b000100},
        {6'b000100, 7'b0001000, 6'b001000},
        {6'b000000, 7'b0010000, 6'b001000},
        {6'b000010, 7'b0100000, 6'b010000},
        {6'b000010, 7'b0000000, 6'b000000},
        {6'b000001, 7'b1000000, 6'b100000},
        {6'b000001, 7'b1000000, 6'b000000},
        {6'b110010, 7'b0100001, 6'b010011},
        {6'b000000, 7'b0000000, 6'b000000}
    };

    logic        clk = 0, rst_n = 0;
    logic [31:0] cnt_in = 0, ts_in = 0;
    logic        sw_trig = 0, cmp_match = 0, idx_in = 0, ext_in = 0;
    logic        zero_cnt = 0, qerr_in = 0, qerr_clr = 0;
    logic [6:0]  trig_en = 0;
    logic        rd_en = 0, ovf_clr = 0;
    logic [1:0]  rd_sel = 0;
    logic [31:0] rd_data;
    logic        rd_miss, q_empty, ovf_flag;
    logic [4:0]  q_level;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] e_cnt [16];
    logic [31:0] e_ts  [16];
    logic [5:0]  e_rsn [16];
    int n_exp = 0;
    logic [31:0] d;
    logic        m;

    snap_capture_queue u_snap_capture_queue (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .ts_in(ts_in), .sw_trig(sw_trig),
        .cmp_match(cmp_match), .idx_in(idx_in), .ext_in(ext_in), .zero_cnt(zero_cnt),
        .qerr_in(qerr_in), .qerr_clr(qerr_clr), .trig_en(trig_en), .rd_en(rd_en),
        .rd_sel(rd_sel), .ovf_clr(ovf_clr), .rd_data(rd_data), .rd_miss(rd_miss),
        .q_empty(q_empty), .q_level(q_level), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data, output logic miss);
        @(negedge clk);
        rd_en = 1; rd_sel = sel;
        @(negedge clk);
        rd_en = 0;
        data = rd_data; miss = rd_miss;
    endtask

    task automatic push_sw(input logic [31:0] c, input logic [31:0] t);
        @(negedge clk);
        sw_trig = 1; cnt_in = c; ts_in = t;
        @(negedge clk);
        sw_trig = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R3 reset empty", {31'd0, q_empty}, 1);
        chk("R3 reset level", {27'd0, q_level}, 0);
        chk("R10 reset ovf", {31'd0, ovf_flag}, 0);
        chk("R5 reset data", rd_data, 0);

        // table walk: R1 R2 R6 R7 R11
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {sw_trig, cmp_match, idx_in, ext_in, zero_cnt, qerr_in} = VEC[i][18:13];
            trig_en = VEC[i][12:6];
            cnt_in = 32'd100 + 32'(i);
            ts_in  = 32'd1000 + 32'(i);
            if (VEC[i][5:0] != 0) begin
                e_cnt[n_exp] = cnt_in; e_ts[n_exp] = ts_in; e_rsn[n_exp] = VEC[i][5:0];
                n_exp++;
            end
        end
        @(negedge clk);
        {sw_trig, cmp_match, idx_in, ext_in, zero_cnt, qerr_in} = 6'b0;
        trig_en = 0;
        chk("R3 level after table", {27'd0, q_level}, 32'(n_exp));
        for (int k = 0; k < n_exp; k++) begin
            rd(2'd0, d, m); chk("R1 count", d, e_cnt[k]);
            rd(2'd1, d, m); chk("R1 timestamp", d, e_ts[k]);
            rd(2'd2, d, m); chk("R2 R6 R11 reason", d, {26'd0, e_rsn[k]});
        end
        chk("R3 empty after drain", {31'd0, q_empty}, 1);

        rd(2'd0, d, m);
        chk("R8 empty read data", d, 0);
        chk("R8 empty read miss", {31'd0, m}, 1);
        rd(2'd1, d, m);
        chk("R8 hold cleared", d, 0);

        for (int k = 0; k < 17; k++) push_sw(32'd200 + 32'(k), 32'd5000 + 32'(k));
        chk("R4 level full", {27'd0, q_level}, 16);
        chk("R10 ovf set", {31'd0, ovf_flag}, 1);
        rd(2'd0, d, m);
        chk("R4 oldest dropped", d, 201);
        for (int k = 17; k < 20; k++) push_sw(32'd200 + 32'(k), 32'd5000 + 32'(k));
        rd(2'd1, d, m);
        chk("R5 held timestamp", d, 5001);
        rd(2'd2, d, m);
        chk("R5 held reason", d, 1);
        chk("R10 ovf still set", {31'd0, ovf_flag}, 1);
        @(negedge clk); ovf_clr = 1;
        @(negedge clk); ovf_clr = 0;
        chk("R10 ovf cleared", {31'd0, ovf_flag}, 0);

        @(negedge clk);
        rd_en = 1; rd_sel = 0; sw_trig = 1; cnt_in = 300; ts_in = 6000;
        @(negedge clk);
        rd_en = 0; sw_trig = 0;
        chk("R9 swap head", rd_data, 204);
        chk("R9 swap level", {27'd0, q_level}, 16);
        chk("R9 swap no ovf", {31'd0, ovf_flag}, 0);
        rd(2'd1, d, m);
        chk("R5 held ts after swap", d, 5004);
        for (int k = 0; k < 16; k++) begin
            rd(2'd0, d, m);
            if (k == 0)  chk("R4 first after swap", d, 205);
            if (k == 15) chk("R9 new entry kept", d, 300);
        end
        chk("R3 empty again", {31'd0, q_empty}, 1);

        trig_en = 7'b1000000;
        @(negedge clk); qerr_in = 1; cnt_in = 55;
        @(negedge clk); qerr_in = 0;
        chk("R7 spent ignores error", {27'd0, q_level}, 0);
        @(negedge clk); qerr_clr = 1;
        @(negedge clk); qerr_clr = 0; qerr_in = 1; cnt_in = 77; ts_in = 7777;
        @(negedge clk); qerr_in = 0;
        chk("R7 rearmed level", {27'd0, q_level}, 1);
        rd(2'd0, d, m);
        chk("R7 rearmed count", d, 77);
        rd(2'd2, d, m);
        chk("R7 rearmed reason", d, 32);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule